// File: doc/BRIEF.md
# Switchable Glitch-Free Clock Prescaler

This block turns a master clock into a slower clock for downstream logic, at one half, one quarter, one eighth or one sixteenth of the master rate. Software chooses the ratio by writing a 2-bit select code with a one-cycle write strobe. The divided clock comes straight from a flip-flop. A matching single-master-cycle enable pulse marks the start of every divided period, so logic on the master clock can use it as a clock enable instead of the divided clock.

A new ratio does not take effect at once. The block keeps the ratio in force until its free-running 4-bit phase counter wraps from 15 to 0. At that point every supported ratio is at a period boundary and the divided clock is just falling. The switch therefore never produces a shortened high or low phase, and it completes within 16 master cycles of the write. A busy flag covers the wait. A second write made while busy replaces the pending code and does not restart the wait.

Top module: `clk_prescaler`

## Requirements
- R1: Select code s (00, 01, 10, 11) gives a period of 2^(s+1) master cycles: the output is low for 2^s cycles, then high for 2^s cycles. Let c be the count of master cycles since reset, modulo 16. The output equals bit s of c. The first cycle after reset release has c = 1.
- R2: Reset is synchronous and active low. While it is held: the divided clock is 0, the enable is 1, busy is 0, the phase count is 0 and code 11 (one sixteenth) is in force.
- R3: A written code takes effect only at the master edge where c goes from 15 to 0. Until that edge the previous code stays in force.
- R4: Busy goes high on the edge that samples a write and falls on the switchover edge. A write sampled on the switchover edge itself takes effect on that edge, and busy stays low.
- R5: A write while busy replaces the pending code and leaves the switchover edge unchanged. The last code written is the one that takes effect.
- R6: Busy is never high for more than 15 consecutive master cycles. A ratio change therefore completes within 16 master cycles of its write, whatever the previous ratio.
- R7: Every completed high or low phase of the divided clock lasts exactly half the period of the code in force either at the start of that phase or at its end. No runt phase occurs.
- R8: The enable output is high in exactly one cycle of each divided period: the cycle in which the low (s+1) bits of c are all zero. That is the first cycle of the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_i | input | 1 | One-cycle write strobe for the select code |
| sel_i | input | 2 | Requested select code: 00 /2, 01 /4, 10 /8, 11 /16 |
| clk_div_o | output | 1 | Registered divided clock |
| clk_en_o | output | 1 | One-master-cycle pulse at the start of each divided period |
| busy_o | output | 1 | A requested ratio is waiting for the switchover |

## Verification
The assertions assume that the strobe and select code are synchronous to the master clock and settle well before each sampling edge. They also assume that no property is expected to span an edge where reset is sampled low. The bench changes inputs only on falling edges. It pulses reset only between complete tests, and discards any phase measurement cut short by reset. It writes codes at random phase-count positions, writes during the busy window, and writes exactly on the wrap cycle. Every write therefore meets a defined switchover edge.

// File: rtl/clkpre_pkg.sv
// Shared sizes and types for the switchable clock prescaler.
// Assumes the number of ratios equals the phase-counter width, since
// ratio 2^(s+1) uses bit s of the counter.
package clkpre_pkg;
    localparam int CNT_W      = 4;
    localparam int NUM_RATIOS = CNT_W;
    localparam int SEL_W      = $clog2(NUM_RATIOS);

    typedef logic [SEL_W-1:0] ratio_sel_t;
    typedef logic [CNT_W-1:0] phase_cnt_t;

    localparam ratio_sel_t SLOWEST_SEL = ratio_sel_t'(NUM_RATIOS - 1);
endpackage

// File: rtl/clkpre_counter.sv
// Free-running phase counter for the prescaler.
// It counts master cycles modulo 2^CNT_W. It gives the present count, the
// count after the next edge, and a wrap flag that is high while the count
// is all ones. Assumes a synchronous active-low reset.
module clkpre_counter #(
    parameter int CNT_W = clkpre_pkg::CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    // Next count, wrapping naturally at the counter width.
    always_comb begin
        cnt_nxt_o = cnt_q + CNT_W'(1);
    end

    // Phase register, cleared by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_nxt_o;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = &cnt_q;
endmodule

// File: rtl/clkpre_ratio_ctl.sv
// Ratio selection control. It holds the code in force, the pending code and
// the busy flag. A written code is adopted only on the edge where the phase
// counter wraps. Assumes wr_i and sel_i are synchronous to clk_i.
module clkpre_ratio_ctl #(
    parameter int SEL_W = clkpre_pkg::SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             wrap_i,
    output logic [SEL_W-1:0] sel_o,
    output logic [SEL_W-1:0] sel_nxt_o,
    output logic             busy_o
);
    localparam logic [SEL_W-1:0] RST_SEL = {SEL_W{1'b1}};

    logic [SEL_W-1:0] sel_q, pend_q, pend_nxt;
    logic             busy_q, busy_nxt;

    // Next-state decision: store the pending code, switch at the wrap.
    always_comb begin
        sel_nxt_o = sel_q;
        pend_nxt  = pend_q;
        busy_nxt  = busy_q;
        if (wr_i) pend_nxt = sel_i;
        if (wrap_i) begin
            if (wr_i)        sel_nxt_o = sel_i;
            else if (busy_q) sel_nxt_o = pend_q;
            busy_nxt = 1'b0;
        end else if (wr_i) begin
            busy_nxt = 1'b1;
        end
    end

    // State registers; reset selects the slowest ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q  <= RST_SEL;
            pend_q <= RST_SEL;
            busy_q <= 1'b0;
        end else begin
            sel_q  <= sel_nxt_o;
            pend_q <= pend_nxt;
            busy_q <= busy_nxt;
        end
    end

    assign sel_o  = sel_q;
    assign busy_o = busy_q;

    AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(sel_q)); // R3

    AST_BUSY_CLEARS_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> !busy_q); // R4

    AST_WRITE_KEEPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wrap_i) |=> busy_q); // R5
endmodule

// File: rtl/clkpre_out_gen.sv
// Output stage. It registers the divided clock and the period-start enable
// from the next phase count and the ratio in force after the next edge, so
// both outputs come straight from flip-flops. Assumes that ratio code s
// uses counter bit s.
module clkpre_out_gen #(
    parameter int CNT_W = clkpre_pkg::CNT_W,
    parameter int SEL_W = clkpre_pkg::SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [SEL_W-1:0] sel_nxt_i,
    input  logic             wrap_i,
    output logic             div_o,
    output logic             en_o
);
    logic [CNT_W-1:0] low_mask;
    logic             div_q, en_q;

    // Mask of the counter bits that lie within one divided period.
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign low_mask[g] = (sel_nxt_i >= SEL_W'(g));
    end

    // Registered divided clock and enable; reset is the start of a period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            div_q <= cnt_nxt_i[sel_nxt_i];
            en_q  <= ((cnt_nxt_i & low_mask) == '0);
        end
    end

    assign div_o = div_q;
    assign en_o  = en_q;

    AST_HIGH_BEFORE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |-> div_q); // R7

    AST_LOW_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> (!div_q && en_q)); // R7

    AST_EN_IN_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |-> !div_q); // R8
endmodule

// File: rtl/clk_prescaler.sv
// Top of the switchable glitch-free clock prescaler. It divides clk_i by
// 2, 4, 8 or 16, deferring ratio changes to the phase-counter wrap.
// Assumes a synchronous active-low reset and inputs that are synchronous
// to clk_i.
module clk_prescaler (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [1:0] sel_i,
    output logic       clk_div_o,
    output logic       clk_en_o,
    output logic       busy_o
);
    import clkpre_pkg::*;

    phase_cnt_t cnt, cnt_nxt;
    ratio_sel_t sel_cur, sel_nxt;
    logic       wrap;

    clkpre_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap)
    );

    clkpre_ratio_ctl #(.SEL_W(SEL_W)) u_ctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_i),
        .sel_i     (sel_i),
        .wrap_i    (wrap),
        .sel_o     (sel_cur),
        .sel_nxt_o (sel_nxt),
        .busy_o    (busy_o)
    );

    clkpre_out_gen #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_nxt_i (cnt_nxt),
        .sel_nxt_i (sel_nxt),
        .wrap_i    (wrap),
        .div_o     (clk_div_o),
        .en_o      (clk_en_o)
    );

    AST_BUSY_ENDS_IN_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt == '0) |-> !busy_o); // R6

    AST_RATIO_HELD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !wr_i) |=> $stable(sel_cur)); // R3
endmodule

// File: tb/clk_prescaler_tb_top.sv
// Self-checking bench for clk_prescaler. A cycle model built from the
// requirements predicts every output. A phase tracker checks the length of
// each high and low phase, and directed tests cover the corner cases.
module clk_prescaler_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_i = 1'b0;
    logic [1:0] sel_i = 2'b00;
    logic       clk_div_o, clk_en_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    clk_prescaler dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_i),
        .clk_div_o(clk_div_o), .clk_en_o(clk_en_o), .busy_o(busy_o)
    );

    always #10 clk_i = ~clk_i; // 50 MHz

    // Requirement model: phase count, code in force, pending code, busy.
    logic [3:0] cnt_m;
    logic [1:0] sel_m, pend_m;
    logic       busy_m;
    logic       model_ok = 1'b0;

    always @(posedge clk_i) begin
        model_ok <= 1'b1;
        if (!rst_ni) begin
            cnt_m <= 4'd0; sel_m <= 2'd3; pend_m <= 2'd3; busy_m <= 1'b0;
        end else begin
            cnt_m <= cnt_m + 4'd1;
            if (wr_i) pend_m <= sel_i;
            if (cnt_m == 4'd15) begin
                if (wr_i)        sel_m <= sel_i;
                else if (busy_m) sel_m <= pend_m;
                busy_m <= 1'b0;
            end else if (wr_i) begin
                busy_m <= 1'b1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, phase-length tracking and busy-run tracking.
    int  ph_len = 0;
    int  ph_sel = 3;
    logic ph_lvl = 1'b0;
    logic ph_ok = 1'b0;
    int  busy_run = 0;

    always @(negedge clk_i) begin
        if (model_ok) begin
            check("R1/R3", "clk_div", clk_div_o, int'(cnt_m[sel_m]));
            check("R8", "clk_en", clk_en_o, int'((cnt_m & ((4'd2 << sel_m) - 4'd1)) == 4'd0));
            check("R4/R5", "busy", busy_o, busy_m);
            if (!rst_ni) begin
                ph_ok = 1'b0; ph_len = 0; ph_lvl = 1'b0; busy_run = 0;
            end else begin
                if (clk_div_o == ph_lvl) ph_len++;
                else begin
                    if (ph_ok) begin
                        n_cmp++;
                        if (ph_len != (1 << ph_sel) && ph_len != (1 << sel_m)) begin
                            n_bad++;
                            $display("FAIL R7 phase length actual=%0d expected=%0d or %0d",
                                     ph_len, 1 << ph_sel, 1 << sel_m);
                        end
                    end
                    ph_ok = 1'b1; ph_lvl = clk_div_o; ph_len = 1; ph_sel = sel_m;
                end
                if (busy_o) busy_run++;
                else begin
                    if (busy_run > 0) check("R6", "busy run <= 15", int'(busy_run <= 15), 1);
                    busy_run = 0;
                end
            end
        end
    end

    // Stimulus table: {select code, cycles to hold after the write}.
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'd37}, {2'd1, 8'd41}, {2'd2, 8'd45}, {2'd3, 8'd39},
        {2'd1, 8'd50}, {2'd3, 8'd33}, {2'd0, 8'd43}, {2'd2, 8'd36},
        {2'd0, 8'd47}, {2'd3, 8'd40}, {2'd2, 8'd38}, {2'd1, 8'd44},
        {2'd0, 8'd35}, {2'd2, 8'd42}
    };

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic write_sel(input logic [1:0] s);
        wr_i = 1'b1; sel_i = s;
        @(negedge clk_i);
        wr_i = 1'b0;
    endtask

    task automatic wait_cnt(input logic [3:0] v);
        do @(negedge clk_i); while (cnt_m != v);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk_i);
    endtask

    initial begin
        idle(3);
        // R2: reset state
        check("R2", "div in reset", clk_div_o, 0);
        check("R2", "en in reset", clk_en_o, 1);
        check("R2", "busy in reset", busy_o, 0);
        rst_ni = 1'b1;
        // R2: one-sixteenth after reset, high from count 8
        wait_cnt(4'd7);
        check("R2", "div at count 7", clk_div_o, 0);
        @(negedge clk_i);
        check("R2", "div at count 8", clk_div_o, 1);

        // R1 R3: table of ratio changes
        for (int v = 0; v < NV; v++) begin
            write_sel(VEC[v][9:8]);
            idle(int'(VEC[v][7:0]));
        end
        wait_idle();

        // R5: second write while busy replaces the pending code
        write_sel(2'd0);
        wait_idle();
        wait_cnt(4'd2);
        write_sel(2'd3);
        write_sel(2'd1);
        check("R5", "busy after replacing write", busy_o, 1);
        wait_cnt(4'd15);
        check("R5", "old ratio kept before wrap", clk_div_o, 1);
        wait_cnt(4'd2);
        check("R5", "div at count 2 under /4", clk_div_o, 1);
        wait_cnt(4'd4);
        check("R5", "div at count 4 under /4", clk_div_o, 0);

        // R4: write on the wrap cycle takes effect at once
        wait_cnt(4'd15);
        wr_i = 1'b1; sel_i = 2'd0;
        @(negedge clk_i);
        wr_i = 1'b0;
        check("R4", "busy after write at wrap", busy_o, 0);
        check("R4", "en at count 0", clk_en_o, 1);
        @(negedge clk_i);
        check("R4", "div at count 1 under /2", clk_div_o, 1);

        // R6: slowest-to-fastest change written right after the wrap
        write_sel(2'd3);
        wait_idle();
        wait_cnt(4'd0);
        write_sel(2'd0);
        idle(40);

        // R2: reset in mid-run returns to the reset state
        write_sel(2'd1);
        idle(3);
        rst_ni = 1'b0;
        idle(3);
        check("R2", "div in mid-run reset", clk_div_o, 0);
        check("R2", "en in mid-run reset", clk_en_o, 1);
        check("R2", "busy in mid-run reset", busy_o, 0);
        rst_ni = 1'b1;
        wait_cnt(4'd8);
        check("R2", "slowest ratio after mid-run reset", clk_div_o, 1);
        idle(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule